// File: doc/BRIEF.md
# Byte-Wide Configuration Port Receiver

This block sits on the target side of a byte-wide parallel loading port. On every rising clock edge it samples an active-low chip select, an active-low write strobe and an 8-bit data bus. A byte is taken when the port is selected, the strobe is asserted, and the block is not busy. The byte goes into a one-entry holding register, which is presented downstream as a valid/data pair with a ready input.

The busy output tells the host that the holding register is still occupied and the consumer is not ready. A host that sees busy must keep the same byte on the bus. The byte is then taken on the first edge at which busy is low.

The port also checks for a protocol violation: the write strobe changing level between two consecutive edges at which chip select is asserted. When this happens the block raises a one-cycle abort pulse. It then ignores all writes until chip select is seen deasserted at an edge.

Top module: `cfg_byte_rx`

## Requirements
- R1: At a rising edge where sel_n=0, wr_n=0, busy=0 and no abort is detected, din is captured; from the next cycle out_valid=1 and out_data equals that byte.
- R2: busy is 1 exactly when the holding register is full (out_valid=1) and out_ready=0; it follows out_ready in the same cycle.
- R3: While out_valid=1 and out_ready=0, out_data stays unchanged and out_valid stays 1 on the next cycle.
- R4: A byte presented while busy=1 is not captured; if the host holds it on the bus, it is captured at the first edge with busy=0.
- R5: If sel_n=0 at two consecutive edges and wr_n differs between them, abort_pulse is 1 for exactly the following cycle, and that byte is not captured.
- R6: After an abort, writes are ignored until an edge with sel_n=1; from the edge after that, capture works normally again.
- R7: Synchronous active-high rst empties the holding register, clears busy and abort_pulse, and forgets the strobe history.
- R8: At an edge with sel_n=1, nothing is captured and no abort is raised, whatever wr_n and din are.
- R9: With out_ready=1 held high, a byte may be captured at every edge; draining the old byte and loading a new one happen on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | DATA_W | Configuration byte from host |
| busy | output | 1 | Holding register occupied and consumer stalled |
| out_valid | output | 1 | Holding register holds a byte |
| out_data | output | DATA_W | Held byte |
| out_ready | input | 1 | Consumer accepts the held byte this cycle |
| abort_pulse | output | 1 | One-cycle flag for a strobe change during a selected burst |

## Verification
The bench builds the block with the default DATA_W of 8, which is the width the port protocol defines.

At that width, distinct byte patterns make every capture, stall and re-capture visible on out_data. Toggling out_ready brings both simultaneous drain-and-load and long stalls within reach. Strobe sequences exercise the abort entry, the lockout, and the return to idle.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    localparam int BYTE_W = 8;

    // Port condition seen at one clock edge, in active-high form.
    typedef struct packed {
        logic sel;
        logic wr;
    } port_ctl_t;

    typedef enum logic [0:0] {
        RX_IDLE  = 1'b0,
        RX_LOCK  = 1'b1
    } rx_state_t;

    function automatic port_ctl_t decode_pins(input logic sel_n, input logic wr_n);
        port_ctl_t c;
        c.sel = ~sel_n;
        c.wr  = ~wr_n;
        return c;
    endfunction

    // Strobe level changed across two consecutive selected edges.
    function automatic logic strobe_flipped(input port_ctl_t now_c, input port_ctl_t prev_c);
        return now_c.sel && prev_c.sel && (now_c.wr != prev_c.wr);
    endfunction

endpackage

// File: rtl/cfgrx_ctrl.sv
module cfgrx_ctrl
    import cfgrx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic wr_n,
    input  logic busy,
    output logic load,
    output logic abort_pulse
);

    port_ctl_t cur_c;
    port_ctl_t prev_c;
    rx_state_t state_q;
    rx_state_t state_d;
    logic      violation;

    always_comb begin
        cur_c = decode_pins(sel_n, wr_n);
    end

    always_comb begin
        violation = (state_q == RX_IDLE) && strobe_flipped(cur_c, prev_c);
        load      = (state_q == RX_IDLE) && !violation && cur_c.sel && cur_c.wr && !busy;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (violation) state_d = RX_LOCK;
            RX_LOCK: if (!cur_c.sel) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_c      <= '0;
            state_q     <= RX_IDLE;
            abort_pulse <= 1'b0;
        end else begin
            prev_c      <= cur_c;
            state_q     <= state_d;
            abort_pulse <= violation;
        end
    end

endmodule

// File: rtl/cfgrx_hold.sv
module cfgrx_hold #(
    parameter int DATA_W = cfgrx_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              busy
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              drain;

    always_comb begin
        drain     = full_q && out_ready;
        busy      = full_q && !out_ready;
        out_valid = full_q;
        out_data  = data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (load) begin
                full_q <= 1'b1;
                data_q <= din;
            end else if (drain) begin
                full_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx #(
    parameter int DATA_W = cfgrx_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              abort_pulse
);

    logic load;

    cfgrx_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sel_n       (sel_n),
        .wr_n        (wr_n),
        .busy        (busy),
        .load        (load),
        .abort_pulse (abort_pulse)
    );

    cfgrx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .din       (din),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .busy      (busy)
    );

endmodule

// File: rtl/cfg_byte_rx_chk.sv
module cfg_byte_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              wr_n,
    input logic              busy,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ready,
    input logic              abort_pulse
);

    p_busy_needs_byte_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (out_valid && !out_ready));

    p_stall_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_abort_once_r5: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> !abort_pulse);

    p_abort_cause_r5: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> ($past(!sel_n) && $past(!sel_n, 2) && ($past(wr_n) != $past(wr_n, 2))));

    p_unselected_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_n && !out_valid) |=> (!out_valid && !abort_pulse));

    p_reset_clears_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && !abort_pulse && !busy));

endmodule

bind cfg_byte_rx cfg_byte_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_n       (sel_n),
    .wr_n        (wr_n),
    .busy        (busy),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_ready   (out_ready),
    .abort_pulse (abort_pulse)
);

// File: tb/cfg_byte_rx_tb.sv
module cfg_byte_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [W-1:0] din = '0;
    logic         out_ready = 1'b1;
    logic         busy;
    logic         out_valid;
    logic [W-1:0] out_data;
    logic         abort_pulse;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_byte_rx #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .din(din),
        .busy(busy), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .abort_pulse(abort_pulse)
    );

    // Behavioural reference: protocol state kept as plain bits and a queue.
    bit         m_full, m_locked, m_psel, m_pwr, m_pulse;
    logic [W-1:0] m_q[$];
    logic [W-1:0] accepted[$];

    always @(posedge clk) begin
        bit s, w, stall, flip, take;
        s = !sel_n; w = !wr_n;
        if (rst) begin
            m_q.delete(); m_locked = 0; m_psel = 0; m_pwr = 0; m_pulse = 0;
        end else begin
            stall = (m_q.size() != 0) && !out_ready;
            flip  = !m_locked && s && m_psel && (w != m_pwr);
            take  = !m_locked && !flip && s && w && !stall;
            if (m_q.size() != 0 && out_ready) void'(m_q.pop_front());
            if (take) begin
                m_q.push_back(din);
                accepted.push_back(din);
            end
            m_pulse  = flip;
            m_locked = m_locked ? s : flip;
            m_psel = s; m_pwr = w;
        end
        m_full = (m_q.size() != 0);
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle at the falling edge, then compare every output to the model.
    task automatic cyc(input bit r, input bit s_n, input bit w_n, input logic [W-1:0] d, input bit rdy);
        @(negedge clk);
        rst = r; sel_n = s_n; wr_n = w_n; din = d; out_ready = rdy;
        #1;
        check("R2 busy", {7'b0, busy}, {7'b0, m_full && !rdy});
        check("R1 out_valid", {7'b0, out_valid}, {7'b0, m_full});
        if (m_full) check("R3 out_data", out_data, m_q[0]);
        check("R5 abort_pulse", {7'b0, abort_pulse}, {7'b0, m_pulse});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 8'h00, 1);
        cyc(0, 1, 1, 8'h00, 1);
        check("R7 reset valid", {7'b0, out_valid}, 8'h00);
        check("R7 reset busy", {7'b0, busy}, 8'h00);

        // R1 / R9: streaming with consumer ready
        accepted.delete();
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 8'h10 + 8'(i), 1);
        cyc(0, 1, 1, 8'h00, 1);
        check("R9 stream count", 8'(accepted.size()), 8'd5);
        check("R1 last byte", accepted[4], 8'h14);

        // R4: stall, host holds next byte while busy
        cyc(0, 1, 1, 8'h00, 1);
        cyc(0, 0, 0, 8'hA5, 0);
        cyc(0, 0, 0, 8'h3C, 0);
        check("R2 busy when stalled", {7'b0, busy}, 8'h01);
        cyc(0, 0, 0, 8'h3C, 0);
        check("R3 held byte", out_data, 8'hA5);
        cyc(0, 0, 0, 8'h3C, 1);
        cyc(0, 1, 1, 8'h00, 1);
        check("R4 recaptured byte", out_data, 8'h3C);
        cyc(0, 1, 1, 8'h00, 1);

        // R8: strobe toggling while unselected
        accepted.delete();
        cyc(0, 1, 0, 8'h77, 1);
        cyc(0, 1, 1, 8'h78, 1);
        cyc(0, 1, 0, 8'h79, 1);
        cyc(0, 1, 1, 8'h00, 1);
        check("R8 nothing captured", 8'(accepted.size()), 8'd0);
        check("R8 no abort", {7'b0, abort_pulse}, 8'h00);

        // R5 / R6: strobe changes during a selected burst
        cyc(0, 0, 1, 8'h55, 1);
        cyc(0, 0, 0, 8'h56, 1);
        cyc(0, 0, 0, 8'h57, 1);
        check("R5 abort pulse", {7'b0, abort_pulse}, 8'h01);
        cyc(0, 0, 1, 8'h58, 1);
        check("R5 pulse one cycle", {7'b0, abort_pulse}, 8'h00);
        cyc(0, 0, 0, 8'h59, 1);
        cyc(0, 0, 0, 8'h5A, 1);
        check("R6 locked ignores writes", 8'(accepted.size()), 8'd0);
        cyc(0, 1, 1, 8'h00, 1);
        cyc(0, 0, 0, 8'h66, 1);
        cyc(0, 1, 1, 8'h00, 1);
        check("R6 capture after release", out_data, 8'h66);

        // R7: reset with a byte held
        cyc(0, 0, 0, 8'h99, 0);
        cyc(0, 1, 1, 8'h00, 0);
        check("R3 stalled valid", {7'b0, out_valid}, 8'h01);
        cyc(1, 1, 1, 8'h00, 0);
        cyc(0, 1, 1, 8'h00, 0);
        check("R7 reset empties", {7'b0, out_valid}, 8'h00);
        check("R7 reset busy low", {7'b0, busy}, 8'h00);

        // mixed traffic with ready toggling
        for (int i = 0; i < 40; i++)
            cyc(0, (i % 7) == 6, 0, 8'(i * 13), (i % 3) != 0);
        cyc(0, 1, 1, 8'h00, 1);
        cyc(0, 1, 1, 8'h00, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule